// File: doc/BRIEF.md
# Temporal Crosstalk-Avoidance Wire Coder

This block moves a payload across a parallel on-chip bus so that two adjacent wires never switch in opposite directions between one bus cycle and the next. Every wire carries two payload bits per block. Each two-bit pair becomes a four-symbol code word, and the wire sends that word over four consecutive bus cycles. The bus therefore runs at twice the payload bit rate. Because neighbours never switch against each other, the worst delay class on any wire is the one with twice the coupling term, not four times. A decoder at the far end collects four symbols per wire and returns the original pairs. It raises an error flag when a word matches no valid code.

There are three code modes. The first is return-to-zero: every data bit is followed by a zero slot. The second is a single thermometer codebook in which symbols only rise inside a block. The third alternates between a rising codebook and a falling codebook, so the coded activity stays equal to the raw activity. All wires share one codebook phase. When the code mode changes between blocks, one all-zero guard slot is inserted, so no boundary between blocks of different modes can produce opposite transitions.

The payload side uses a valid/ready handshake. A pair word is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low while a block is in flight and rises again in the cycle that presents the block's last symbol. The sender may hold `in_valid` for as long as it needs to. On the bus and decoder side, the strobes qualify the data and there is no back-pressure.

Top module: `xtalk_temporal_coder`

## Requirements
- R1: While `rst_n` is low, `in_ready` is 1, `bus_out` is all zero, and `bus_stb` and `out_valid` are 0.
- R2: `in_ready` is 1 when no block is in flight, is 0 in the cycle after an acceptance, and is 1 again while the last symbol is driven. Back-to-back blocks in the same mode are therefore accepted exactly 4 cycles apart.
- R3: Wire w carries the pair `in_data[2w+1:2w]`. Its four code symbols go out most significant first, on consecutive cycles with `bus_stb` high. When the mode is unchanged, the first symbol appears in the cycle right after the acceptance.
- R4: Mode value 0 (return-to-zero) sends the pair {b1,b0} as the word b1,0,b0,0.
- R5: Mode value 1 (thermometer) sends 00 as 0000, 01 as 0001, 10 as 0011 and 11 as 0111.
- R6: Mode value 2 (alternating) uses codebook A (00→0001, 01→0011, 10→0111, 11→1111) and codebook B (00→0000, 01→1000, 10→1100, 11→1110). Successive mode-2 blocks alternate A, B, A, and so on. The phase is A after reset and after any block in another mode.
- R7: If the effective mode at acceptance differs from the previous block's mode (which is 0 after reset), the bus is driven all zero for one cycle with `bus_stb` low before the first symbol.
- R8: Between any two consecutive bus cycles, no wire of `bus_out` rises while another falls.
- R9: The decoder shifts in `bus_in` on every `bus_in_stb`. It samples `rx_mode` at the first strobe of a block and follows the same phase rule as R6. One cycle after the fourth strobe it pulses `out_valid` high for exactly one cycle, with the pairs on `out_data` in the layout of R3.
- R10: `out_err` is 1 together with `out_valid` if and only if some wire's four symbols match no code word of the block's mode and phase.
- R11: Mode value 3 behaves exactly like mode value 0. This includes the guard rule, so switching between 0 and 3 inserts no guard slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Code mode for the coder, sampled at acceptance |
| in_data | input | 2*WIRES | Payload, two bits per wire |
| in_valid | input | 1 | Payload valid |
| in_ready | output | 1 | Coder can accept a payload |
| bus_out | output | WIRES | Coded bus symbols |
| bus_stb | output | 1 | High when `bus_out` carries a code symbol |
| bus_in | input | WIRES | Coded symbols into the decoder |
| bus_in_stb | input | 1 | Strobe qualifying `bus_in` |
| rx_mode | input | 2 | Code mode for the decoder, sampled at a block's first strobe |
| out_data | output | 2*WIRES | Recovered pairs |
| out_valid | output | 1 | One-cycle pulse when a block is decoded |
| out_err | output | 1 | Invalid code word seen, qualified by `out_valid` |

## Verification
The bench builds the block with the default of four wires. With four wires, a single payload puts all four pair values on the bus at once, and the two inner wires each sit between two aggressors, so every neighbour combination of R8 occurs. Mode-2 sequences cover both codebook phases, and a mode change in the middle of the sequence returns the phase to A. Payloads chosen for mixed thermometer endings, followed by switches into the other modes, exercise the guard slot. Error words are fed to the decoder directly through its own input.

// File: rtl/xtc_pkg.sv
`timescale 1ns/1ps
package xtc_pkg;
  localparam logic [1:0] XM_RTZ   = 2'd0;
  localparam logic [1:0] XM_THERM = 2'd1;
  localparam logic [1:0] XM_ALT   = 2'd2;

  // Mode 3 folds onto return-to-zero.
  function automatic logic [1:0] xtc_norm(input logic [1:0] m);
    return (m == 2'd3) ? XM_RTZ : m;
  endfunction

  function automatic logic [3:0] xtc_therm(input logic [1:0] p);
    case (p)
      2'd0:    return 4'b0000;
      2'd1:    return 4'b0001;
      2'd2:    return 4'b0011;
      default: return 4'b0111;
    endcase
  endfunction

  // Code word for one wire, symbol [3] is sent first.
  function automatic logic [3:0] xtc_encode(input logic [1:0] m, input logic ph,
                                            input logic [1:0] p);
    logic [3:0] t;
    t = xtc_therm(p);
    case (m)
      XM_THERM: return t;
      XM_ALT:   return ph ? {t[0], t[1], t[2], t[3]} : {t[2:0], 1'b1};
      default:  return {p[1], 1'b0, p[0], 1'b0};
    endcase
  endfunction

  // Inverse search over the four pair values: {hit, pair}.
  function automatic logic [2:0] xtc_decode(input logic [1:0] m, input logic ph,
                                            input logic [3:0] w);
    logic [2:0] r;
    r = 3'b000;
    for (int k = 0; k < 4; k++) begin
      if (xtc_encode(m, ph, 2'(k)) == w) r = {1'b1, 2'(k)};
    end
    return r;
  endfunction
endpackage

// File: rtl/xtc_encoder.sv
`timescale 1ns/1ps
module xtc_encoder
  import xtc_pkg::*;
#(
  parameter int WIRES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode,
  input  logic [2*WIRES-1:0]   in_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic [WIRES-1:0]     bus_q,
  output logic                 bus_stb
);
  localparam int SYM_LAST = 3;

  logic [3:0] code_d [WIRES];
  logic [3:0] code_q [WIRES];
  logic [1:0] mode_n, prev_mode_q, blk_mode_q, cnt_q;
  logic       busy_q, guard_q, phase_q, accept, need_guard;

  assign mode_n     = xtc_norm(mode);
  assign in_ready   = !busy_q || (cnt_q == 2'd0 && !guard_q);
  assign accept     = in_valid && in_ready;
  assign need_guard = (mode_n != prev_mode_q);

  for (genvar w = 0; w < WIRES; w++) begin : g_enc
    assign code_d[w] = xtc_encode(mode_n, phase_q, in_data[2*w +: 2]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      guard_q     <= 1'b0;
      cnt_q       <= 2'd0;
      phase_q     <= 1'b0;
      prev_mode_q <= XM_RTZ;
      blk_mode_q  <= XM_RTZ;
      bus_q       <= '0;
      bus_stb     <= 1'b0;
      for (int w = 0; w < WIRES; w++) code_q[w] <= 4'd0;
    end else if (accept) begin
      busy_q      <= 1'b1;
      cnt_q       <= 2'(SYM_LAST);
      blk_mode_q  <= mode_n;
      prev_mode_q <= mode_n;
      phase_q     <= (mode_n == XM_ALT) ? !phase_q : 1'b0;
      if (need_guard) begin
        guard_q <= 1'b1;
        bus_stb <= 1'b0;
        bus_q   <= '0;
        for (int w = 0; w < WIRES; w++) code_q[w] <= code_d[w];
      end else begin
        guard_q <= 1'b0;
        bus_stb <= 1'b1;
        for (int w = 0; w < WIRES; w++) begin
          bus_q[w]  <= code_d[w][3];
          code_q[w] <= {code_d[w][2:0], 1'b0};
        end
      end
    end else if (busy_q && (guard_q || cnt_q != 2'd0)) begin
      bus_stb <= 1'b1;
      guard_q <= 1'b0;
      if (!guard_q) cnt_q <= cnt_q - 2'd1;
      for (int w = 0; w < WIRES; w++) begin
        bus_q[w]  <= code_q[w][3];
        code_q[w] <= {code_q[w][2:0], 1'b0};
      end
    end else if (busy_q) begin
      busy_q  <= 1'b0;
      bus_stb <= 1'b0;
    end
  end

  // R8
  no_opposite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((|(bus_q & ~$past(bus_q))) && (|(~bus_q & $past(bus_q)))));

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R4
  rtz_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stb && blk_mode_q == XM_RTZ && !cnt_q[0]) |-> (bus_q == '0));

  // R5
  therm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stb && blk_mode_q == XM_THERM && cnt_q != 2'd3) |-> ((~bus_q & $past(bus_q)) == '0));

  // R7
  guard_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && xtc_norm(mode) != prev_mode_q) |=> (!bus_stb && bus_q == '0));
endmodule

// File: rtl/xtc_decoder.sv
`timescale 1ns/1ps
module xtc_decoder
  import xtc_pkg::*;
#(
  parameter int WIRES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode,
  input  logic [WIRES-1:0]     bus_d,
  input  logic                 bus_d_stb,
  output logic [2*WIRES-1:0]   out_data,
  output logic                 out_valid,
  output logic                 out_err
);
  logic [2:0]         sh_q [WIRES];
  logic [1:0]         cnt_q, blk_mode_q;
  logic               phase_q;
  logic [WIRES-1:0]   hit_w;
  logic [2*WIRES-1:0] pair_d;

  for (genvar w = 0; w < WIRES; w++) begin : g_dec
    assign {hit_w[w], pair_d[2*w +: 2]} = xtc_decode(blk_mode_q, phase_q, {sh_q[w], bus_d[w]});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= 2'd0;
      blk_mode_q <= XM_RTZ;
      phase_q    <= 1'b0;
      out_data   <= '0;
      out_valid  <= 1'b0;
      out_err    <= 1'b0;
      for (int w = 0; w < WIRES; w++) sh_q[w] <= 3'd0;
    end else begin
      out_valid <= 1'b0;
      if (bus_d_stb) begin
        cnt_q <= cnt_q + 2'd1;
        for (int w = 0; w < WIRES; w++) sh_q[w] <= {sh_q[w][1:0], bus_d[w]};
        if (cnt_q == 2'd0) blk_mode_q <= xtc_norm(mode);
        if (cnt_q == 2'd3) begin
          out_valid <= 1'b1;
          out_data  <= pair_d;
          out_err   <= !(&hit_w);
          phase_q   <= (blk_mode_q == XM_ALT) ? !phase_q : 1'b0;
        end
      end
    end
  end

  // R9
  valid_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(bus_d_stb));

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
endmodule

// File: rtl/xtalk_temporal_coder.sv
`timescale 1ns/1ps
module xtalk_temporal_coder #(
  parameter int WIRES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode,
  input  logic [2*WIRES-1:0]   in_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic [WIRES-1:0]     bus_out,
  output logic                 bus_stb,
  input  logic [WIRES-1:0]     bus_in,
  input  logic                 bus_in_stb,
  input  logic [1:0]           rx_mode,
  output logic [2*WIRES-1:0]   out_data,
  output logic                 out_valid,
  output logic                 out_err
);
  xtc_encoder #(.WIRES(WIRES)) u_enc (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .bus_q(bus_out), .bus_stb(bus_stb)
  );

  xtc_decoder #(.WIRES(WIRES)) u_dec (
    .clk(clk), .rst_n(rst_n), .mode(rx_mode), .bus_d(bus_in), .bus_d_stb(bus_in_stb),
    .out_data(out_data), .out_valid(out_valid), .out_err(out_err)
  );
endmodule

// File: tb/test_xtalk_temporal_coder.sv
`timescale 1ns/1ps
module test_xtalk_temporal_coder;
  localparam int WIRES = 4;
  localparam int PW = 2 * WIRES;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0, rx_mode = 2'd0;
  logic [PW-1:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_ready, bus_stb, out_valid, out_err;
  logic [WIRES-1:0] bus_out, bus_in;
  logic [PW-1:0] out_data;
  logic inj = 1'b0, inj_stb = 1'b0, bus_in_stb;
  logic [WIRES-1:0] inj_bus = '0;

  assign bus_in     = inj ? inj_bus : bus_out;
  assign bus_in_stb = inj ? inj_stb : bus_stb;

  xtalk_temporal_coder #(.WIRES(WIRES)) i_xtalk_temporal_coder (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .bus_out(bus_out), .bus_stb(bus_stb), .bus_in(bus_in),
    .bus_in_stb(bus_in_stb), .rx_mode(rx_mode), .out_data(out_data),
    .out_valid(out_valid), .out_err(out_err)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, sym_n = 0, rx_n = 0, opp_cnt = 0, nblk = 0;
  bit done = 0;
  logic [WIRES-1:0] sym_log [256];
  logic [WIRES-1:0] prev_bus = '0;
  logic [PW-1:0] rx_data [64];
  logic rx_err [64];
  logic [1:0] b_mode [64];
  bit b_ph [64];
  logic [PW-1:0] b_data [64];
  bit bph = 0;
  logic [1:0] last_raw = 2'd0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (bus_stb) begin sym_log[sym_n] = bus_out; sym_n++; end
      if ((|(bus_out & ~prev_bus)) && (|(~bus_out & prev_bus))) opp_cnt++;
      prev_bus = bus_out;
      if (out_valid && rx_n < 64) begin rx_data[rx_n] = out_data; rx_err[rx_n] = out_err; rx_n++; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Code tables taken from R4, R5, R6.
  function automatic logic [3:0] ref_code(input logic [1:0] m, input bit ph, input logic [1:0] p);
    if (m == 2'd1) begin
      case (p) 2'd0: return 4'b0000; 2'd1: return 4'b0001; 2'd2: return 4'b0011; default: return 4'b0111; endcase
    end else if (m == 2'd2 && !ph) begin
      case (p) 2'd0: return 4'b0001; 2'd1: return 4'b0011; 2'd2: return 4'b0111; default: return 4'b1111; endcase
    end else if (m == 2'd2) begin
      case (p) 2'd0: return 4'b0000; 2'd1: return 4'b1000; 2'd2: return 4'b1100; default: return 4'b1110; endcase
    end
    return {p[1], 1'b0, p[0], 1'b0};
  endfunction

  task automatic drain();
    repeat (8) @(negedge clk);
  endtask

  task automatic send_block(input logic [1:0] m, input logic [PW-1:0] d,
                            output int lat, output int acc);
    logic [1:0] mn;
    if (m != last_raw) drain();
    mode = m; rx_mode = m; last_raw = m;
    in_data = d; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    acc = cyc;
    in_valid = 1'b0;
    lat = bus_stb ? 1 : 2;
    mn = (m == 2'd3) ? 2'd0 : m;
    b_mode[nblk] = mn; b_ph[nblk] = bph; b_data[nblk] = d; nblk++;
    bph = (mn == 2'd2) ? ~bph : 1'b0;
  endtask

  task automatic verify(input int from, input int to);
    for (int b = from; b < to; b++) begin
      bit sok = 1;
      logic [WIRES-1:0] exp_s, bad_act, bad_exp;
      logic [3:0] cw;
      string tag;
      bad_act = '0; bad_exp = '0;
      tag = (b_mode[b] == 2'd1) ? "R5" : (b_mode[b] == 2'd2) ? "R6" : "R4";
      for (int j = 0; j < 4; j++) begin
        for (int w = 0; w < WIRES; w++) begin
          cw = ref_code(b_mode[b], b_ph[b], b_data[b][2*w +: 2]); // R3 wire mapping
          exp_s[w] = cw[3-j];
        end
        if (sok && sym_log[4*b+j] !== exp_s) begin sok = 0; bad_act = sym_log[4*b+j]; bad_exp = exp_s; end
      end
      chk(sok, tag, $sformatf("block %0d symbols", b), bad_act, bad_exp);
      chk(rx_data[b] === b_data[b] && rx_err[b] === 1'b0, "R9",
          $sformatf("block %0d decode", b), {rx_err[b], rx_data[b]}, {1'b0, b_data[b]});
    end
  endtask

  task automatic test_therm();
    int lat, acc, f;
    f = nblk;
    send_block(2'd1, 8'h1B, lat, acc); chk(lat == 2, "R7", "guard after reset mode 0", lat, 2);
    send_block(2'd1, 8'hE4, lat, acc); chk(lat == 1, "R3", "first symbol latency", lat, 1);
    send_block(2'd1, 8'h00, lat, acc);
    send_block(2'd1, 8'hFF, lat, acc);
    send_block(2'd1, 8'h4D, lat, acc);
    drain(); verify(f, nblk);
  endtask

  task automatic test_rtz();
    int lat, acc, f;
    f = nblk;
    send_block(2'd0, 8'h9C, lat, acc); chk(lat == 2, "R7", "guard on mode 1 to 0", lat, 2);
    send_block(2'd0, 8'h63, lat, acc); chk(lat == 1, "R3", "rtz latency", lat, 1);
    drain(); verify(f, nblk);
  endtask

  task automatic test_alt();
    int lat, acc, f;
    f = nblk;
    send_block(2'd1, 8'h39, lat, acc);
    send_block(2'd2, 8'h1B, lat, acc); chk(lat == 2, "R7", "guard on mode 1 to 2", lat, 2);
    send_block(2'd2, 8'hE4, lat, acc);
    send_block(2'd2, 8'hA5, lat, acc);
    send_block(2'd2, 8'h5A, lat, acc);
    send_block(2'd2, 8'hC3, lat, acc);
    send_block(2'd1, 8'h33, lat, acc);
    send_block(2'd2, 8'h0F, lat, acc); // R6: phase back to A
    send_block(2'd2, 8'hF0, lat, acc);
    drain(); verify(f, nblk);
  endtask

  task automatic test_mode3();
    int lat, acc, f;
    f = nblk;
    send_block(2'd3, 8'h6C, lat, acc); chk(lat == 2, "R11", "mode 3 guard from mode 2", lat, 2);
    send_block(2'd0, 8'h93, lat, acc); chk(lat == 1, "R11", "no guard between 3 and 0", lat, 1);
    drain(); verify(f, nblk);
  endtask

  task automatic test_b2b();
    int lat, f;
    int acc [4];
    f = nblk;
    for (int i = 0; i < 4; i++) begin
      send_block(2'd0, 8'(8'h21 * (i + 1)), lat, acc[i]);
      chk(in_ready == 1'b0, "R2", "ready low in flight", in_ready, 0);
      if (i > 0) chk(acc[i] - acc[i-1] == 4, "R2", "back-to-back spacing", acc[i] - acc[i-1], 4);
    end
    drain(); verify(f, nblk);
    chk(in_ready == 1'b1, "R2", "ready when idle", in_ready, 1);
  endtask

  task automatic inject(input logic [1:0] m, input logic [WIRES*4-1:0] words,
                        input bit exp_err, input logic [PW-1:0] exp_d, input bit chk_d);
    rx_mode = m; inj = 1'b1;
    for (int j = 0; j < 4; j++) begin
      for (int w = 0; w < WIRES; w++) inj_bus[w] = words[4*w + 3 - j];
      inj_stb = 1'b1;
      @(negedge clk);
    end
    inj_stb = 1'b0;
    chk(out_valid == 1'b1, "R9", "valid after fourth strobe", out_valid, 1);
    chk(out_err == exp_err, "R10", "error flag", out_err, exp_err);
    if (chk_d) chk(out_data == exp_d, "R9", "injected decode", out_data, exp_d);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "valid is one pulse", out_valid, 0);
    inj = 1'b0;
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && bus_out == '0 && bus_stb == 1'b0 && out_valid == 1'b0, "R1",
        "reset state", {in_ready, bus_out, bus_stb, out_valid}, 7'b1000000);
    rst_n = 1'b1;
    @(negedge clk);
    test_therm();
    test_rtz();
    test_alt();
    test_mode3();
    test_b2b();
    chk(opp_cnt == 0, "R8", "opposite transitions seen", opp_cnt, 0);
    // wire words listed wire3..wire0
    inject(2'd1, 16'h000A, 1'b1, '0, 1'b0);          // 1010 not thermometer
    inject(2'd1, 16'h0017, 1'b0, 8'h07, 1'b1);       // 0111, 0001 valid
    inject(2'd0, 16'h0400, 1'b1, '0, 1'b0);          // 0100 breaks zero slot
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule